// File: doc/BRIEF.md
# Programmable Threshold Timer

This block is a counter timer that counts active edges of a slow external tick input, sampled in the system clock domain. The tick input passes through a synchronizer. A polarity control chooses whether rising or falling transitions count. When the count reaches a programmed threshold, the block raises an interrupt request. In cyclic mode it then returns to zero on the following active edge and keeps running. In one-shot mode it stops by clearing its own enable bit.

The interrupt output works in one of two modes. In pulse mode it is high for exactly one system clock. In level mode it stays high until software clears the pending bit by writing 1 to it. Software may rewrite the threshold while the timer runs. The count can be read at any time, and reading it does not affect counting. Register access uses a plain single-cycle write port and a combinational read port.

The controller is a three-state machine:
- ST_IDLE: stopped, count held.
- ST_RUN: counting.
- ST_RELOAD: the threshold has been reached in cyclic mode, and the count waits for the next active edge to return to zero.

The transitions are:
- IDLE→RUN when enable is 1. The count is cleared on this transition.
- RUN→RELOAD on a hit in cyclic mode.
- RUN→IDLE on a hit in one-shot mode.
- RUN→IDLE and RELOAD→IDLE when enable is 0.
- RELOAD→RUN on an active edge.

Top module: `thr_timer`

## Requirements
- R1: After reset, the control, threshold, count and pending registers read 0 and `irq` is 0.
- R2: The register addresses are: 0 = control, 1 = threshold, 2 = count (read only), 3 = status. The control bits are: bit0 enable, bit1 cyclic (1) or one-shot (0), bit2 polarity (0 counts rising edges, 1 counts falling edges), bit3 level-mode interrupt. All control bits read back as written.
- R3: In the running state, each active edge of `tick_in` adds 1 to the count, and inactive edges leave it unchanged. The new count is visible after the third rising `clk` edge following the change of `tick_in`.
- R4: In cyclic mode, the active edge that makes the count equal to the threshold is a hit. The next active edge sets the count to 0, and counting then continues.
- R5: In one-shot mode, a hit clears the enable bit (control bit0) and holds the count at the threshold. Later edges leave the count unchanged.
- R6: In pulse mode, `irq` rises on the same clock as the count update of a hit and is high for exactly one cycle.
- R7: In level mode, `irq` stays high after a hit until software writes 1 to status bit0. Writing 0 to that bit leaves `irq` high.
- R8: The threshold can be rewritten while the timer runs. A value at or below the current count gives no hit until the count has wrapped past its all-ones value through 0 and reaches the new threshold.
- R9: Reading any register, including the count, never changes the count or the following counting sequence.
- R10: Setting enable while the timer is stopped clears the count to 0. Clearing enable stops counting and holds the count.
- R11: Status bit0 (pending) is set by every hit, in both interrupt modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | External counting input, asynchronous to clk |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Combinational read data |
| irq | output | 1 | Interrupt request, pulse or level |

## Verification
A change on `tick_in` reaches the count, the pending bit and `irq` at the third rising clock edge: two synchronizer stages, then the state update. A register write becomes visible at the clock edge that samples the strobe. Clearing the count on enable takes one more edge, because the state machine leaves ST_IDLE one cycle after enable is set. The driver tasks change inputs on falling edges and wait exactly three falling edges after each tick change. The scoreboard monitor then samples one nanosecond later, so every expected count and `irq` value is compared after its update edge and before the next one. A second `irq` sample one cycle later checks that a pulse has ended.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_THR  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    localparam int B_EN  = 0;
    localparam int B_CYC = 1;
    localparam int B_POL = 2;
    localparam int B_LVL = 3;
    localparam int CTRL_BITS = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_RELOAD = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic pol,
    output logic act_edge
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= tick_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    logic rise, fall;
    assign rise     =  sync_q[SYNC_STAGES-1] & ~prev_q;
    assign fall     = ~sync_q[SYNC_STAGES-1] &  prev_q;
    assign act_edge = pol ? fall : rise;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cyc,
    input  logic             act_edge,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] cnt,
    output logic             hit,
    output logic             busy,
    output logic             reloading
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

    assign cnt_inc = cnt_q + CNT_W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hit     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (act_edge) begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == thr) begin
                        hit     = 1'b1;
                        state_d = cyc ? ST_RELOAD : ST_IDLE;
                    end
                end
            end
            ST_RELOAD: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (act_edge) begin
                    cnt_d   = '0;
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cnt       = cnt_q;
    assign busy      = (state_q != ST_IDLE);
    assign reloading = (state_q == ST_RELOAD);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              hit,
    output logic              en,
    output logic              cyc,
    output logic              pol,
    output logic              lvl,
    output logic [CNT_W-1:0]  thr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    logic [CTRL_BITS-1:0] ctrl_q;
    logic [CNT_W-1:0]     thr_q;
    logic                 pend_q, pulse_q;
    logic                 wr_ctrl, wr_thr, clr_pend;

    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign wr_thr   = wr_en && (wr_addr == A_THR);
    assign clr_pend = wr_en && (wr_addr == A_STAT) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wr_data[CTRL_BITS-1:0];
        end else if (hit && !ctrl_q[B_CYC]) begin
            ctrl_q[B_EN] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      thr_q <= '0;
        else if (wr_thr) thr_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= hit;
            if (hit)           pend_q <= 1'b1;
            else if (clr_pend) pend_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: rd_data[CTRL_BITS-1:0] = ctrl_q;
            A_THR:  rd_data = thr_q;
            A_CNT:  rd_data = cnt;
            A_STAT: rd_data[0] = pend_q;
            default: rd_data = '0;
        endcase
    end

    assign en  = ctrl_q[B_EN];
    assign cyc = ctrl_q[B_CYC];
    assign pol = ctrl_q[B_POL];
    assign lvl = ctrl_q[B_LVL];
    assign thr = thr_q;
    assign irq = lvl ? pend_q : pulse_q;
endmodule

// File: rtl/thr_timer.sv
module thr_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    logic             en_w, cyc_w, pol_w, lvl_w;
    logic [CNT_W-1:0] thr_w, cnt_w;
    logic             hit_w, busy_w, reload_w, act_edge_w;

    tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (tick_in),
        .pol      (pol_w),
        .act_edge (act_edge_w)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_w),
        .cyc       (cyc_w),
        .act_edge  (act_edge_w),
        .thr       (thr_w),
        .cnt       (cnt_w),
        .hit       (hit_w),
        .busy      (busy_w),
        .reloading (reload_w)
    );

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .cnt     (cnt_w),
        .hit     (hit_w),
        .en      (en_w),
        .cyc     (cyc_w),
        .pol     (pol_w),
        .lvl     (lvl_w),
        .thr     (thr_w),
        .rd_data (rd_data),
        .irq     (irq)
    );
endmodule

// File: rtl/thr_timer_chk.sv
module thr_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             act_edge,
    input logic             hit,
    input logic             busy,
    input logic             reloading,
    input logic             en,
    input logic             cyc,
    input logic             lvl,
    input logic             irq,
    input logic [CNT_W-1:0] cnt
);
    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !act_edge) |=> $stable(cnt));

    // R4
    cyc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reloading && en && act_edge) |=> (cnt == '0));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cyc && !wr_en) |=> !en);

    // R6
    pulse_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !lvl && !wr_en) |=> irq);

    // R6
    pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !lvl && !wr_en) |=> !irq);

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && lvl && !wr_en) |=> irq);

    // R10
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && en) |=> (busy && cnt == '0));
endmodule

bind thr_timer thr_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .act_edge  (act_edge_w),
    .hit       (hit_w),
    .busy      (busy_w),
    .reloading (reload_w),
    .en        (en_w),
    .cyc       (cyc_w),
    .lvl       (lvl_w),
    .irq       (irq),
    .cnt       (cnt_w)
);

// File: tb/tb_thr_timer.sv
`timescale 1ns/1ps
module tb_thr_timer;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_in = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit mon_busy = 1'b0;

    always #10 clk = ~clk;

    thr_timer #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    typedef struct {
        bit           is_irq;
        logic [1:0]   addr;
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t sb_q[$];

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            mon_busy = 1'b1;
            begin
                item_t it;
                logic [W-1:0] got;
                it = sb_q.pop_front();
                rd_addr = it.addr;
                #1;
                got = it.is_irq ? W'(irq) : rd_data;
                n_tests++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got 0x%0h expected 0x%0h", it.tag, got, it.exp);
                end
            end
            mon_busy = 1'b0;
        end
    end

    task automatic push_item(bit is_irq, logic [1:0] addr, logic [W-1:0] exp, string tag);
        item_t it;
        it.is_irq = is_irq;
        it.addr   = addr;
        it.exp    = exp;
        it.tag    = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    task automatic exp_reg(logic [1:0] addr, logic [W-1:0] exp, string tag);
        push_item(1'b0, addr, exp, tag);
    endtask

    task automatic exp_irq(logic v, string tag);
        push_item(1'b1, 2'd0, W'(v), tag);
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // set tick level; return once the change has reached the count
    task automatic tick_set(logic v);
        @(negedge clk);
        tick_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        exp_reg(2'd0, 8'h00, "R1 ctrl");
        exp_reg(2'd1, 8'h00, "R1 thr");
        exp_reg(2'd2, 8'h00, "R1 cnt");
        exp_reg(2'd3, 8'h00, "R1 stat");
        exp_irq(1'b0, "R1 irq");

        // cyclic, rising edges, pulse mode, threshold 3
        wr(2'd1, 8'd3);
        wr(2'd0, 8'h03);
        repeat (2) @(negedge clk);
        exp_reg(2'd0, 8'h03, "R2 ctrl readback");
        exp_reg(2'd2, 8'd0, "R10 start count");

        tick_set(1'b1);
        exp_reg(2'd2, 8'd1, "R3 rising edge counted");
        tick_set(1'b0);
        exp_reg(2'd2, 8'd1, "R3 falling edge ignored");
        tick_set(1'b1);
        tick_set(1'b0);
        exp_reg(2'd2, 8'd2, "R3 second edge");
        tick_set(1'b1);
        exp_reg(2'd2, 8'd3, "R4 count at threshold");
        exp_irq(1'b1, "R6 pulse high on hit");
        @(negedge clk);
        exp_irq(1'b0, "R6 pulse one cycle");
        exp_reg(2'd3, 8'd1, "R11 pending set in pulse mode");
        wr(2'd3, 8'd1);
        exp_reg(2'd3, 8'd0, "R7 pending cleared by write 1");
        tick_set(1'b0);
        exp_reg(2'd2, 8'd3, "R4 held until next active edge");
        tick_set(1'b1);
        exp_reg(2'd2, 8'd0, "R4 reload to zero");
        tick_set(1'b0);
        tick_set(1'b1);
        exp_reg(2'd2, 8'd1, "R4 counting resumes");

        // R9 repeated reads do not disturb
        for (int i = 0; i < 4; i++) exp_reg(2'd2, 8'd1, "R9 repeated count read");
        exp_reg(2'd1, 8'd3, "R9 thr read");
        tick_set(1'b0);
        tick_set(1'b1);
        exp_reg(2'd2, 8'd2, "R9 count after reads");

        // R8 threshold lowered below count while running
        wr(2'd1, 8'd1);
        tick_set(1'b0);
        tick_set(1'b1);
        exp_reg(2'd2, 8'd3, "R8 no hit below count");
        exp_irq(1'b0, "R8 no irq below count");
        for (int i = 0; i < 252; i++) begin
            tick_set(1'b0);
            tick_set(1'b1);
        end
        exp_reg(2'd2, 8'd255, "R8 count reaches all ones");
        tick_set(1'b0);
        tick_set(1'b1);
        exp_reg(2'd2, 8'd0, "R8 wrap to zero");
        exp_irq(1'b0, "R8 no irq at wrap");
        tick_set(1'b0);
        tick_set(1'b1);
        exp_reg(2'd2, 8'd1, "R8 new threshold reached");
        exp_irq(1'b1, "R8 irq at new threshold");

        // R8 threshold raised while in reload
        wr(2'd1, 8'd2);
        tick_set(1'b0);
        tick_set(1'b1);
        exp_reg(2'd2, 8'd0, "R8 reload after raise");
        tick_set(1'b0);
        tick_set(1'b1);
        tick_set(1'b0);
        tick_set(1'b1);
        exp_reg(2'd2, 8'd2, "R8 raised threshold reached");
        exp_irq(1'b1, "R8 irq raised threshold");

        // R10 disable holds count
        wr(2'd0, 8'h02);
        tick_set(1'b0);
        tick_set(1'b1);
        exp_reg(2'd2, 8'd2, "R10 disabled count held");
        wr(2'd3, 8'd1);

        // one-shot, falling edges, level mode, threshold 2
        wr(2'd1, 8'd2);
        wr(2'd0, 8'h0D);
        repeat (2) @(negedge clk);
        exp_reg(2'd2, 8'd0, "R10 re-enable clears count");
        exp_reg(2'd0, 8'h0D, "R2 ctrl readback oneshot");
        exp_irq(1'b0, "R7 irq low before hit");
        tick_set(1'b0);
        exp_reg(2'd2, 8'd1, "R3 falling edge counted");
        tick_set(1'b1);
        exp_reg(2'd2, 8'd1, "R3 rising edge ignored");
        tick_set(1'b0);
        exp_reg(2'd2, 8'd2, "R5 count at threshold");
        exp_irq(1'b1, "R7 level irq on hit");
        exp_reg(2'd0, 8'h0C, "R5 enable cleared");
        repeat (5) @(negedge clk);
        exp_irq(1'b1, "R7 level irq held");
        tick_set(1'b1);
        tick_set(1'b0);
        exp_reg(2'd2, 8'd2, "R5 stopped after hit");
        wr(2'd3, 8'd0);
        exp_irq(1'b1, "R7 write 0 no effect");
        wr(2'd3, 8'd1);
        exp_irq(1'b0, "R7 cleared by write 1");
        exp_reg(2'd3, 8'd0, "R11 pending cleared");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule